// File: doc/BRIEF.md
# Micro-operation Datapath Executor

This block is the execute half of a horizontally microcoded processor. Each cycle it takes a 9-bit operation word holding three independent 3-bit fields, A, B and C, and performs up to three register transfers at once. These transfers act on a 16-bit accumulator (AC), a 16-bit data register (DR), an 11-bit address register (AR) and an 11-bit program counter (PC). All selected transfers read the values the registers hold before the clock edge, and all of them commit on that edge.

Main memory lives outside the block and is 2048 words of 16 bits. The block drives the address (always AR) and the write data (always DR) to it, along with a write strobe and a read strobe. The memory returns read data combinationally, and DR captures that data on the edge that ends the read cycle.

Three status bits go back to the microsequencer: the top bit of DR, the top bit of AC, and a flag that is set when AC is zero. Choosing the next microinstruction address is done elsewhere.

Top module: `uop_exec`

## Requirements
- R1: While `rst_n` is low at a rising edge, AC, DR, AR and PC become zero. Both memory strobes stay low as long as `rst_n` is low.
- R2: Field A (`uop_fields[8:6]`) acts on AC as follows: 001 adds DR into AC, 010 clears AC, 011 increments AC, and 100 copies DR into AC. All arithmetic wraps modulo 2^16.
- R3: Field A code 101 loads AR with DR[10:0]. Field A code 110 loads AR with PC.
- R4: Field A code 111 raises `mem_we` during that cycle, with `mem_addr` equal to AR and `mem_wdata` equal to DR, so the word is stored at that edge.
- R5: Field B (`uop_fields[5:3]`) acts on AC as follows: 001 sets AC to AC minus DR (mod 2^16), 010 sets AC to AC OR DR, and 011 sets AC to AC AND DR.
- R6: Field B code 100 raises `mem_re` with `mem_addr` equal to AR, and DR takes `mem_rdata` at that edge.
- R7: Field B acts on DR as follows: 101 copies AC into DR, 110 increments DR, and 111 loads DR[10:0] from PC while DR[15:11] keeps its value.
- R8: Field C (`uop_fields[2:0]`) acts on AC as follows: 001 is AC XOR DR, 010 is the bitwise complement, 011 is a left shift with a zero entering bit 0, and 100 is a right shift with a zero entering bit 15.
- R9: Field C code 101 increments PC (wrapping at 11 bits). Field C code 110 loads PC from AR.
- R10: Code 000 in any field does nothing, and field C code 111 (reserved) also does nothing. With no active operation, no register changes and neither strobe is raised.
- R11: Operations from different fields commit on the same edge, and each one reads the register values from before that edge.
- R12: When more than one field targets AC in the same cycle, field C wins over field B, and field B wins over field A.
- R13: `st_dr_msb` equals DR[15], `st_ac_msb` equals AC[15], and `st_ac_zero` is 1 exactly when all 16 bits of AC are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uop_fields | input | 9 | Operation fields: A at [8:6], B at [5:3], C at [2:0] |
| mem_addr | output | 11 | Memory word address (AR) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 16 | Memory write data (DR) |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| ac_out | output | 16 | Accumulator value |
| dr_out | output | 16 | Data register value |
| ar_out | output | 11 | Address register value |
| pc_out | output | 11 | Program counter value |
| st_dr_msb | output | 1 | DR bit 15 |
| st_ac_msb | output | 1 | AC bit 15 |
| st_ac_zero | output | 1 | AC is all zeros |

## Verification
The assertions assume two things about the inputs. First, `uop_fields` is known and stable across each rising edge. Second, `mem_rdata` is defined during any cycle that raises `mem_re`, because the read check compares DR against the read data from the previous cycle. The bench meets both conditions. It changes the fields only at falling edges and returns them to all-zero after each step. Its memory model is cleared to zero before reset, so every read returns a defined word. Apart from the one task written to exercise the R12 priority order, the stimulus never sends AC operations from two fields in the same cycle.

// File: rtl/uop_pkg.sv
// Package: shared widths, field codes and decoded select types for the
// micro-operation executor. Assumes three 3-bit fields per operation word.
package uop_pkg;
    localparam int FIELD_W = 3;

    // Field A codes
    typedef enum logic [2:0] {
        A_NOP = 3'd0, A_ADD = 3'd1, A_CLR = 3'd2, A_INC = 3'd3,
        A_MOVDR = 3'd4, A_ARDR = 3'd5, A_ARPC = 3'd6, A_MEMWR = 3'd7
    } a_op_e;

    // Field B codes
    typedef enum logic [2:0] {
        B_NOP = 3'd0, B_SUB = 3'd1, B_OR = 3'd2, B_AND = 3'd3,
        B_MEMRD = 3'd4, B_DRAC = 3'd5, B_DRINC = 3'd6, B_DRPC = 3'd7
    } b_op_e;

    // Field C codes
    typedef enum logic [2:0] {
        C_NOP = 3'd0, C_XOR = 3'd1, C_NOT = 3'd2, C_SHL = 3'd3,
        C_SHR = 3'd4, C_PCINC = 3'd5, C_PCAR = 3'd6, C_RSV = 3'd7
    } c_op_e;

    typedef enum logic [3:0] {
        ACF_HOLD, ACF_ADD, ACF_CLR, ACF_INC, ACF_MOV, ACF_SUB, ACF_OR,
        ACF_AND, ACF_XOR, ACF_NOT, ACF_SHL, ACF_SHR
    } ac_fn_e;

    typedef enum logic [2:0] {DRS_HOLD, DRS_MEM, DRS_AC, DRS_INC, DRS_PC} dr_sel_e;
    typedef enum logic [1:0] {ARS_HOLD, ARS_DR, ARS_PC} ar_sel_e;
    typedef enum logic [1:0] {PCS_HOLD, PCS_INC, PCS_AR} pc_sel_e;
endpackage

// File: rtl/uop_decode.sv
// Module: uop_decode
// Turns the three operation fields into one select per register plus the
// memory strobes. Assumes fields are known each cycle; AC conflicts are
// resolved with field C over field B over field A.
module uop_decode
    import uop_pkg::*;
(
    input  logic [FIELD_W-1:0] fa,
    input  logic [FIELD_W-1:0] fb,
    input  logic [FIELD_W-1:0] fc,
    output ac_fn_e             ac_fn,
    output dr_sel_e            dr_sel,
    output ar_sel_e            ar_sel,
    output pc_sel_e            pc_sel,
    output logic               dec_we,
    output logic               dec_re
);
    ac_fn_e fn_a, fn_b, fn_c;

    // Field A: AC function, AR select, write strobe
    always_comb begin
        fn_a   = ACF_HOLD;
        ar_sel = ARS_HOLD;
        dec_we = 1'b0;
        case (a_op_e'(fa))
            A_ADD:   fn_a = ACF_ADD;
            A_CLR:   fn_a = ACF_CLR;
            A_INC:   fn_a = ACF_INC;
            A_MOVDR: fn_a = ACF_MOV;
            A_ARDR:  ar_sel = ARS_DR;
            A_ARPC:  ar_sel = ARS_PC;
            A_MEMWR: dec_we = 1'b1;
            default: fn_a = ACF_HOLD;
        endcase
    end

    // Field B: AC function, DR select, read strobe
    always_comb begin
        fn_b   = ACF_HOLD;
        dr_sel = DRS_HOLD;
        dec_re = 1'b0;
        case (b_op_e'(fb))
            B_SUB:   fn_b = ACF_SUB;
            B_OR:    fn_b = ACF_OR;
            B_AND:   fn_b = ACF_AND;
            B_MEMRD: begin dr_sel = DRS_MEM; dec_re = 1'b1; end
            B_DRAC:  dr_sel = DRS_AC;
            B_DRINC: dr_sel = DRS_INC;
            B_DRPC:  dr_sel = DRS_PC;
            default: fn_b = ACF_HOLD;
        endcase
    end

    // Field C: AC function and PC select; reserved code is a no-op
    always_comb begin
        fn_c   = ACF_HOLD;
        pc_sel = PCS_HOLD;
        case (c_op_e'(fc))
            C_XOR:   fn_c = ACF_XOR;
            C_NOT:   fn_c = ACF_NOT;
            C_SHL:   fn_c = ACF_SHL;
            C_SHR:   fn_c = ACF_SHR;
            C_PCINC: pc_sel = PCS_INC;
            C_PCAR:  pc_sel = PCS_AR;
            default: fn_c = ACF_HOLD;
        endcase
    end

    // AC arbitration: C before B before A
    always_comb begin
        if (fn_c != ACF_HOLD)      ac_fn = fn_c;
        else if (fn_b != ACF_HOLD) ac_fn = fn_b;
        else                       ac_fn = fn_a;
    end
endmodule

// File: rtl/uop_acc_unit.sv
// Module: uop_acc_unit
// Holds the accumulator and its function unit. Assumes one decoded
// function per cycle; arithmetic wraps at DATA_W bits, shifts fill zero.
module uop_acc_unit
    import uop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ac_fn_e            ac_fn,
    input  logic [DATA_W-1:0] dr_q,
    output logic [DATA_W-1:0] ac_q
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    logic [DATA_W-1:0] ac_d;

    // Next accumulator value for the selected function
    always_comb begin
        case (ac_fn)
            ACF_ADD: ac_d = ac_q + dr_q;
            ACF_CLR: ac_d = '0;
            ACF_INC: ac_d = ac_q + ONE;
            ACF_MOV: ac_d = dr_q;
            ACF_SUB: ac_d = ac_q - dr_q;
            ACF_OR:  ac_d = ac_q | dr_q;
            ACF_AND: ac_d = ac_q & dr_q;
            ACF_XOR: ac_d = ac_q ^ dr_q;
            ACF_NOT: ac_d = ~ac_q;
            ACF_SHL: ac_d = {ac_q[DATA_W-2:0], 1'b0};
            ACF_SHR: ac_d = {1'b0, ac_q[DATA_W-1:1]};
            default: ac_d = ac_q;
        endcase
    end

    // Accumulator register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ac_fn == ACF_HOLD |=> $stable(ac_q)); // R10
    AST_AC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ac_fn == ACF_CLR |=> ac_q == '0); // R2
    AST_AC_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        ac_fn == ACF_NOT |=> ac_q == ~$past(ac_q)); // R8
endmodule

// File: rtl/uop_dr_unit.sv
// Module: uop_dr_unit
// Holds the data register. Assumes mem_rdata is valid in any cycle that
// selects a memory load; the partial PC load keeps the upper bits.
module uop_dr_unit
    import uop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dr_sel_e           dr_sel,
    input  logic [DATA_W-1:0] ac_q,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dr_q
);
    localparam int UP_W = DATA_W - ADDR_W;
    logic [DATA_W-1:0] dr_d;

    // Next data register value
    always_comb begin
        case (dr_sel)
            DRS_MEM: dr_d = mem_rdata;
            DRS_AC:  dr_d = ac_q;
            DRS_INC: dr_d = dr_q + DATA_W'(1);
            DRS_PC:  dr_d = {dr_q[DATA_W-1 -: UP_W], pc_q};
            default: dr_d = dr_q;
        endcase
    end

    // Data register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) dr_q <= '0;
        else        dr_q <= dr_d;
    end

    AST_DR_MEM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dr_sel == DRS_MEM |=> dr_q == $past(mem_rdata)); // R6
    AST_DR_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dr_sel == DRS_PC |=> dr_q[DATA_W-1 -: UP_W] == $past(dr_q[DATA_W-1 -: UP_W])); // R7
endmodule

// File: rtl/uop_addr_unit.sv
// Module: uop_addr_unit
// Holds the address register and program counter. Assumes DATA_W is at
// least ADDR_W; the PC increment wraps at ADDR_W bits.
module uop_addr_unit
    import uop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ar_sel_e           ar_sel,
    input  pc_sel_e           pc_sel,
    input  logic [DATA_W-1:0] dr_q,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q
);
    logic [ADDR_W-1:0] ar_d, pc_d;

    // Next address register value
    always_comb begin
        case (ar_sel)
            ARS_DR:  ar_d = dr_q[ADDR_W-1:0];
            ARS_PC:  ar_d = pc_q;
            default: ar_d = ar_q;
        endcase
    end

    // Next program counter value
    always_comb begin
        case (pc_sel)
            PCS_INC: pc_d = pc_q + ADDR_W'(1);
            PCS_AR:  pc_d = ar_q;
            default: pc_d = pc_q;
        endcase
    end

    // AR and PC registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0;
            pc_q <= '0;
        end else begin
            ar_q <= ar_d;
            pc_q <= pc_d;
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel == PCS_INC |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R9
    AST_AR_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ar_sel == ARS_PC |=> ar_q == $past(pc_q)); // R3
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ar_sel == ARS_HOLD |=> $stable(ar_q)); // R10
endmodule

// File: rtl/uop_exec.sv
// Module: uop_exec
// Top of the micro-operation executor: decodes three fields per cycle and
// commits their transfers together. Assumes an external memory that returns
// read data combinationally from mem_addr.
module uop_exec
    import uop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3*FIELD_W-1:0] uop_fields,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    ac_out,
    output logic [DATA_W-1:0]    dr_out,
    output logic [ADDR_W-1:0]    ar_out,
    output logic [ADDR_W-1:0]    pc_out,
    output logic                 st_dr_msb,
    output logic                 st_ac_msb,
    output logic                 st_ac_zero
);
    logic [FIELD_W-1:0] fa, fb, fc;
    ac_fn_e  ac_fn;
    dr_sel_e dr_sel;
    ar_sel_e ar_sel;
    pc_sel_e pc_sel;
    logic dec_we, dec_re;
    logic [DATA_W-1:0] ac_q, dr_q;
    logic [ADDR_W-1:0] ar_q, pc_q;

    // Split the operation word into its three fields
    assign fa = uop_fields[3*FIELD_W-1 -: FIELD_W];
    assign fb = uop_fields[2*FIELD_W-1 -: FIELD_W];
    assign fc = uop_fields[FIELD_W-1:0];

    uop_decode u_dec (
        .fa(fa), .fb(fb), .fc(fc),
        .ac_fn(ac_fn), .dr_sel(dr_sel), .ar_sel(ar_sel), .pc_sel(pc_sel),
        .dec_we(dec_we), .dec_re(dec_re)
    );

    uop_acc_unit #(.DATA_W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .ac_fn(ac_fn), .dr_q(dr_q), .ac_q(ac_q)
    );

    uop_dr_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dr (
        .clk(clk), .rst_n(rst_n), .dr_sel(dr_sel), .ac_q(ac_q), .pc_q(pc_q),
        .mem_rdata(mem_rdata), .dr_q(dr_q)
    );

    uop_addr_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ar_sel(ar_sel), .pc_sel(pc_sel),
        .dr_q(dr_q), .ar_q(ar_q), .pc_q(pc_q)
    );

    // Memory port: address from AR, data from DR, strobes gated by reset
    assign mem_addr  = ar_q;
    assign mem_wdata = dr_q;
    assign mem_we    = rst_n & dec_we;
    assign mem_re    = rst_n & dec_re;

    // Register and status outputs for the sequencer
    assign ac_out     = ac_q;
    assign dr_out     = dr_q;
    assign ar_out     = ar_q;
    assign pc_out     = pc_q;
    assign st_dr_msb  = dr_q[DATA_W-1];
    assign st_ac_msb  = ac_q[DATA_W-1];
    assign st_ac_zero = (ac_q == '0);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (ac_q == '0 && dr_q == '0 && ar_q == '0 && pc_q == '0)); // R1
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fa == '0 && fb == '0 && fc == FIELD_W'(7)) |=>
        ($stable(ac_q) && $stable(dr_q) && $stable(ar_q) && $stable(pc_q))); // R10
    AST_C_OVER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (fc == FIELD_W'(2) && fb == '0 && fa == FIELD_W'(2)) |=> ac_q == ~$past(ac_q)); // R12
    AST_PARALLEL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (fb == FIELD_W'(5) && fa == FIELD_W'(3)) |=> dr_q == $past(ac_q)); // R11
endmodule

// File: tb/uop_exec_bench.sv
module uop_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  ops;
    logic [10:0] mem_addr, ar_out, pc_out;
    logic        mem_we, mem_re;
    logic [15:0] mem_wdata, mem_rdata, ac_out, dr_out;
    logic        st_dr_msb, st_ac_msb, st_ac_zero;
    logic [15:0] mem [2048];
    int total = 0;
    int bad = 0;
    logic        pre_we, pre_re;
    logic [10:0] pre_addr;
    logic [15:0] pre_wdata;

    always #4 clk = ~clk;

    uop_exec u_uop_exec (
        .clk(clk), .rst_n(rst_n), .uop_fields(ops),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ac_out(ac_out), .dr_out(dr_out), .ar_out(ar_out), .pc_out(pc_out),
        .st_dr_msb(st_dr_msb), .st_ac_msb(st_ac_msb), .st_ac_zero(st_ac_zero)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One operation word for one clock; records port values before the edge
    task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
        @(negedge clk);
        ops = {a, b, c};
        #1;
        pre_we = mem_we; pre_re = mem_re; pre_addr = mem_addr; pre_wdata = mem_wdata;
        @(posedge clk);
        #1;
        ops = '0;
    endtask

    task automatic set_dr(input logic [15:0] v);
        mem[ar_out] = v;
        step(3'd0, 3'd4, 3'd0);
    endtask

    task automatic set_ac(input logic [15:0] v);
        set_dr(v);
        step(3'd4, 3'd0, 3'd0);
    endtask

    task automatic t_reset;
        chk("R1", "ac", ac_out, 0);
        chk("R1", "dr", dr_out, 0);
        chk("R1", "ar", ar_out, 0);
        chk("R1", "pc", pc_out, 0);
        chk("R1", "strobes", {mem_we, mem_re}, 0);
        chk("R13", "zero flag after reset", st_ac_zero, 1);
    endtask

    task automatic t_field_a_acc;
        set_ac(16'h1234);
        chk("R2", "copy DR", ac_out, 16'h1234);
        step(3'd1, 3'd0, 3'd0);
        chk("R2", "add", ac_out, 16'h2468);
        step(3'd3, 3'd0, 3'd0);
        chk("R2", "inc", ac_out, 16'h2469);
        set_dr(16'hFFFF);
        step(3'd1, 3'd0, 3'd0);
        chk("R2", "add wraps", ac_out, 16'h2468);
        step(3'd2, 3'd0, 3'd0);
        chk("R2", "clear", ac_out, 0);
        chk("R13", "zero flag", st_ac_zero, 1);
    endtask

    task automatic t_field_a_ar;
        set_dr(16'hF8AB);
        step(3'd5, 3'd0, 3'd0);
        chk("R3", "AR from DR low bits", ar_out, 11'h0AB);
        step(3'd0, 3'd0, 3'd5);
        step(3'd0, 3'd0, 3'd5);
        step(3'd0, 3'd0, 3'd5);
        chk("R9", "pc after three incs", pc_out, 3);
        step(3'd6, 3'd0, 3'd0);
        chk("R3", "AR from PC", ar_out, 3);
    endtask

    task automatic t_write;
        set_dr(16'hBEEF);
        step(3'd7, 3'd0, 3'd0);
        chk("R4", "we during write", pre_we, 1);
        chk("R4", "addr during write", pre_addr, 3);
        chk("R4", "wdata during write", pre_wdata, 16'hBEEF);
        chk("R4", "stored word", mem[3], 16'hBEEF);
    endtask

    task automatic t_field_b_acc;
        set_ac(16'h0F0F);
        set_dr(16'h00FF);
        step(3'd0, 3'd1, 3'd0);
        chk("R5", "sub", ac_out, 16'h0E10);
        step(3'd0, 3'd2, 3'd0);
        chk("R5", "or", ac_out, 16'h0EFF);
        step(3'd0, 3'd3, 3'd0);
        chk("R5", "and", ac_out, 16'h00FF);
        set_dr(16'h0100);
        step(3'd0, 3'd1, 3'd0);
        chk("R5", "sub underflow", ac_out, 16'hFFFF);
        chk("R13", "ac msb", st_ac_msb, 1);
        chk("R13", "zero flag clear", st_ac_zero, 0);
    endtask

    task automatic t_read;
        mem[ar_out] = 16'h5A5A;
        step(3'd0, 3'd4, 3'd0);
        chk("R6", "re during read", pre_re, 1);
        chk("R6", "addr during read", pre_addr, ar_out);
        chk("R6", "dr loaded", dr_out, 16'h5A5A);
        chk("R13", "dr msb low", st_dr_msb, 0);
        set_dr(16'h8001);
        chk("R13", "dr msb high", st_dr_msb, 1);
    endtask

    task automatic t_field_b_dr;
        logic [10:0] pc_now;
        set_ac(16'h1357);
        set_dr(16'h0000);
        step(3'd0, 3'd5, 3'd0);
        chk("R7", "DR from AC", dr_out, 16'h1357);
        step(3'd0, 3'd6, 3'd0);
        chk("R7", "DR inc", dr_out, 16'h1358);
        set_dr(16'hFFFF);
        step(3'd0, 3'd6, 3'd0);
        chk("R7", "DR inc wraps", dr_out, 16'h0000);
        set_dr(16'hFFFF);
        pc_now = pc_out;
        step(3'd0, 3'd7, 3'd0);
        chk("R7", "DR low from PC", dr_out, {5'h1F, pc_now});
    endtask

    task automatic t_field_c_acc;
        set_ac(16'h00F0);
        set_dr(16'h0FF0);
        step(3'd0, 3'd0, 3'd1);
        chk("R8", "xor", ac_out, 16'h0F00);
        step(3'd0, 3'd0, 3'd2);
        chk("R8", "complement", ac_out, 16'hF0FF);
        step(3'd0, 3'd0, 3'd3);
        chk("R8", "shift left", ac_out, 16'hE1FE);
        step(3'd0, 3'd0, 3'd4);
        chk("R8", "shift right", ac_out, 16'h70FF);
    endtask

    task automatic t_pc;
        logic [10:0] pc_now;
        pc_now = pc_out;
        step(3'd0, 3'd0, 3'd5);
        chk("R9", "pc inc", pc_out, 11'(pc_now + 1));
        set_dr(16'h0123);
        step(3'd5, 3'd0, 3'd0);
        step(3'd0, 3'd0, 3'd6);
        chk("R9", "PC from AR", pc_out, 11'h123);
        set_dr(16'h07FF);
        step(3'd5, 3'd0, 3'd0);
        step(3'd0, 3'd0, 3'd6);
        step(3'd0, 3'd0, 3'd5);
        chk("R9", "pc wraps", pc_out, 0);
    endtask

    task automatic t_idle;
        logic [15:0] a0, d0;
        logic [10:0] r0, p0;
        a0 = ac_out; d0 = dr_out; r0 = ar_out; p0 = pc_out;
        step(3'd0, 3'd0, 3'd0);
        chk("R10", "all nop state", {a0 ^ ac_out, d0 ^ dr_out, r0 ^ ar_out, p0 ^ pc_out}, 0);
        chk("R10", "all nop strobes", {pre_we, pre_re}, 0);
        step(3'd0, 3'd0, 3'd7);
        chk("R10", "reserved state", {a0 ^ ac_out, d0 ^ dr_out, r0 ^ ar_out, p0 ^ pc_out}, 0);
        chk("R10", "reserved strobes", {pre_we, pre_re}, 0);
    endtask

    task automatic t_parallel;
        logic [10:0] pc_now;
        set_ac(16'h0010);
        pc_now = pc_out;
        step(3'd3, 3'd5, 3'd5);
        chk("R11", "ac inc", ac_out, 16'h0011);
        chk("R11", "dr takes old ac", dr_out, 16'h0010);
        chk("R11", "pc inc", pc_out, 11'(pc_now + 1));
        pc_now = pc_out;
        step(3'd6, 3'd6, 3'd3);
        chk("R11", "ar takes old pc", ar_out, pc_now);
        chk("R11", "dr inc", dr_out, 16'h0011);
        chk("R11", "ac shl", ac_out, 16'h0022);
    endtask

    task automatic t_priority;
        set_ac(16'h0010);
        set_dr(16'h0001);
        step(3'd2, 3'd2, 3'd2);
        chk("R12", "C wins", ac_out, 16'hFFEF);
        step(3'd3, 3'd1, 3'd0);
        chk("R12", "B over A", ac_out, 16'hFFEE);
        step(3'd2, 3'd0, 3'd5);
        chk("R12", "A applies when C targets PC", ac_out, 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        rst_n = 1'b0;
        ops = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_field_a_acc();
        t_field_a_ar();
        t_write();
        t_field_b_acc();
        t_read();
        t_field_b_dr();
        t_field_c_acc();
        t_pc();
        t_idle();
        t_parallel();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule